// File: doc/BRIEF.md
# Set-Clear Masked Interrupt Register Bank

This block holds the interrupt registers of a serial bus controller. Event pulses from the controller's datapath land in a sticky status register. Software acknowledges an event by writing a one to its status bit. Each source is gated by a mask bit. Software never writes the mask directly: it uses one register that clears mask bits (enables sources) and another that sets them (disables sources), so a driver can change one source without a read-modify-write. A single registered interrupt line is high whenever any pending status bit is unmasked.

The status register, the mask register and both strobe registers share one bit layout. A two-bit register select chooses the target of a write or of the combinational read. Only the implemented source positions hold state. All other positions read as zero and take no writes and no events.

Top module: `irq_bank_top`

## Requirements
- R1: After reset, status reads 0, every implemented mask bit reads 1 (all sources masked), and `irq` is 0.
- R2: An `evt` pulse on an implemented bit sets that status bit, and the bit stays set until cleared. The bit layout is: 0 completion, 1 data, 2 NACK, 3 timeout, 4 target-ready, 5 RX overflow, 6 TX overflow, 7 RX underflow, 9 arbitration lost.
- R3: A write to status (select 0) clears exactly the bits written as 1 and leaves the others unchanged.
- R4: If an event and a clear hit the same status bit in one cycle, the bit stays set.
- R5: A write to the enable register (select 2) clears the mask bits written as 1. Zero bits leave the mask unchanged.
- R6: A write to the disable register (select 3) sets the mask bits written as 1. Zero bits leave the mask unchanged.
- R7: The mask register (select 1) is read-only, and a write to it changes nothing.
- R8: Bit 8 and bits 10 and above read as zero in status and mask, and ignore events and writes.
- R9: `irq` is registered. After each clock edge it equals the OR of (status AND NOT mask) as they stood before that edge.
- R10: Reads of the enable and disable registers return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 status, 1 mask, 2 enable, 3 disable |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read of the selected register |
| evt | input | DATA_W | Event pulses, one per source bit |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is an event pulse and a write-one-to-clear landing on the same status bit in the same cycle. Random traffic that drives events and writes independently almost never lines them up. The bench therefore has a directed step that raises `evt` on a pending bit while clearing it, alongside random steps that combine event pulses with status writes. The interrupt line's one-cycle lag behind a mask change is checked against a bench model. That model computes `irq` from the register values before each edge.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_MASK    = 2'd1,
    SEL_ENABLE  = 2'd2,
    SEL_DISABLE = 2'd3
  } reg_sel_e;

  localparam int SRC_DONE    = 0;
  localparam int SRC_DATA    = 1;
  localparam int SRC_NACK    = 2;
  localparam int SRC_TMO     = 3;
  localparam int SRC_TGT_RDY = 4;
  localparam int SRC_RX_OVF  = 5;
  localparam int SRC_TX_OVF  = 6;
  localparam int SRC_RX_UNF  = 7;
  localparam int SRC_ARB     = 9;

  localparam logic [15:0] DEFAULT_IMPL =
    (16'd1 << SRC_DONE) | (16'd1 << SRC_DATA) | (16'd1 << SRC_NACK) |
    (16'd1 << SRC_TMO) | (16'd1 << SRC_TGT_RDY) | (16'd1 << SRC_RX_OVF) |
    (16'd1 << SRC_TX_OVF) | (16'd1 << SRC_RX_UNF) | (16'd1 << SRC_ARB);
endpackage

// File: rtl/irqb_status.sv
module irqb_status #(
  parameter int          W    = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] status_q
);
  function automatic logic [W-1:0] sticky_next(input logic [W-1:0] cur,
                                               input logic [W-1:0] clr,
                                               input logic [W-1:0] set);
    return ((cur & ~clr) | set) & IMPL;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= sticky_next(status_q, clr_vec, set_vec);
  end

  // a set bit survives unless cleared
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~$past(clr_vec)) & ~status_q) == '0));
  // an event always leaves its implemented bit set, even against a clear
  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(set_vec) & IMPL) & ~status_q) == '0));
  // a cleared bit with no event drops
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(clr_vec) & ~$past(set_vec)) & status_q) == '0));
endmodule

// File: rtl/irqb_mask.sv
module irqb_mask #(
  parameter int          W    = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] en_vec,
  input  logic [W-1:0] dis_vec,
  output logic [W-1:0] mask_q
);
  function automatic logic [W-1:0] mask_next(input logic [W-1:0] cur,
                                             input logic [W-1:0] en,
                                             input logic [W-1:0] dis);
    return ((cur & ~en) | dis) & IMPL;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= IMPL;
    else        mask_q <= mask_next(mask_q, en_vec, dis_vec);
  end

  p_enable_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(en_vec) & mask_q) == '0));
  p_disable_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(dis_vec) & IMPL) & ~mask_q) == '0));
  p_zero_bits_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((mask_q ^ $past(mask_q)) & ~($past(en_vec) | $past(dis_vec))) == '0));
endmodule

// File: rtl/irqb_line.sv
module irqb_line #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  output logic         irq_q
);
  function automatic logic pending(input logic [W-1:0] st, input logic [W-1:0] mk);
    return |(st & ~mk);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending(status, mask);
  end

  p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == (($past(status) & ~$past(mask)) != '0)));
endmodule

// File: rtl/irq_bank_top.sv
module irq_bank_top
  import irq_bank_pkg::*;
#(
  parameter int               DATA_W = 16,
  parameter logic [DATA_W-1:0] IMPL  = DATA_W'(DEFAULT_IMPL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] evt,
  output logic              irq
);
  localparam logic [DATA_W-1:0] RSVD = ~IMPL;

  reg_sel_e          sel;
  logic [DATA_W-1:0] clr_vec, en_vec, dis_vec;
  logic [DATA_W-1:0] status_q, mask_q;

  assign sel = reg_sel_e'(reg_sel);

  // write strobes brought out as named vectors
  always_comb begin
    clr_vec = '0;
    en_vec  = '0;
    dis_vec = '0;
    if (wr_en) begin
      case (sel)
        SEL_STATUS:  clr_vec = wdata;
        SEL_ENABLE:  en_vec  = wdata;
        SEL_DISABLE: dis_vec = wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_STATUS: rdata = status_q;
      SEL_MASK:   rdata = mask_q;
      default:    rdata = '0;
    endcase
  end

  irqb_status #(.W(DATA_W), .IMPL(IMPL)) u_status (
    .clk(clk), .rst_n(rst_n), .clr_vec(clr_vec), .set_vec(evt), .status_q(status_q));

  irqb_mask #(.W(DATA_W), .IMPL(IMPL)) u_mask (
    .clk(clk), .rst_n(rst_n), .en_vec(en_vec), .dis_vec(dis_vec), .mask_q(mask_q));

  irqb_line #(.W(DATA_W)) u_line (
    .clk(clk), .rst_n(rst_n), .status(status_q), .mask(mask_q), .irq_q(irq));

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rdata & RSVD) == '0));
  p_mask_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd1) |=> $stable(mask_q));
  p_strobe_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel[1]) |-> (rdata == '0));
endmodule

// File: tb/sim_irq_bank_top.sv
`timescale 1ns/1ps
module sim_irq_bank_top;
  localparam int DW = 16;
  localparam logic [DW-1:0] IMPL = 16'h02FF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [DW-1:0] evt = '0;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [DW-1:0] m_st = '0;
  logic [DW-1:0] m_mk = IMPL;
  logic          m_irq = 1'b0;

  always #2.5 clk = ~clk;

  irq_bank_top #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .evt(evt), .irq(irq));

  function automatic logic [DW-1:0] f_status(logic [DW-1:0] st, logic [1:0] s,
                                             logic we, logic [DW-1:0] wd, logic [DW-1:0] ev);
    logic [DW-1:0] r;
    r = st;
    if (we && s == 2'd0) r = r & ~wd;
    return (r | ev) & IMPL;
  endfunction

  function automatic logic [DW-1:0] f_mask(logic [DW-1:0] mk, logic [1:0] s,
                                           logic we, logic [DW-1:0] wd);
    logic [DW-1:0] r;
    r = mk;
    if (we && s == 2'd2) r = r & ~wd;
    if (we && s == 2'd3) r = r | wd;
    return r & IMPL;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic peek(logic [1:0] s, output logic [DW-1:0] v);
    reg_sel = s;
    wr_en = 1'b0;
    #0.3;
    v = rdata;
  endtask

  // one clocked operation, model updated after the edge
  task automatic step(logic [1:0] s, logic we, logic [DW-1:0] wd, logic [DW-1:0] ev);
    reg_sel = s; wr_en = we; wdata = wd; evt = ev;
    @(posedge clk);
    #1;
    wr_en = 1'b0; evt = '0;
    m_irq = |(m_st & ~m_mk);
    m_st  = f_status(m_st, s, we, wd, ev);
    m_mk  = f_mask(m_mk, s, we, wd);
  endtask

  task automatic check_all(string tag);
    logic [DW-1:0] v;
    @(negedge clk);
    peek(2'd0, v); check({tag, " status"}, v, m_st);
    peek(2'd1, v); check({tag, " mask"}, v, m_mk);
    check({tag, " irq R9"}, {{(DW-1){1'b0}}, irq}, {{(DW-1){1'b0}}, m_irq});
  endtask

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_all("R1 reset");
    // R2 event on completion bit, masked so no irq
    step(2'd0, 1'b0, '0, 16'h0001); check_all("R2 event");
    step(2'd0, 1'b0, '0, 16'h0000); check_all("R2 sticky");
    // R5 enable bit 0, irq rises one edge later (R9)
    step(2'd2, 1'b1, 16'h0001, '0); check_all("R5 enable");
    step(2'd0, 1'b0, '0, '0);       check_all("R9 lag");
    step(2'd2, 1'b1, 16'h0000, '0); check_all("R5 zero write");
    // R4 event and clear on same bit
    step(2'd0, 1'b1, 16'h0001, 16'h0001); check_all("R4 event wins");
    // R3 clear exactly the ones written
    step(2'd0, 1'b0, '0, 16'h020A); check_all("R2 more events");
    step(2'd0, 1'b1, 16'h0009, '0); check_all("R3 w1c");
    // R7 mask read-only
    step(2'd1, 1'b1, 16'h0000, '0); check_all("R7 mask ro");
    // R8 reserved bits
    step(2'd0, 1'b0, '0, 16'hFD00); check_all("R8 rsvd events");
    step(2'd3, 1'b1, 16'hFFFF, '0); check_all("R6 disable all");
    step(2'd2, 1'b1, 16'hFFFF, '0); check_all("R8 rsvd enable");
    step(2'd3, 1'b1, 16'h0200, '0); check_all("R6 disable bit9");
    // R10 strobe registers read zero
    @(negedge clk);
    peek(2'd2, v); check("R10 enable reads", v, '0);
    peek(2'd3, v); check("R10 disable reads", v, '0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0]    s;
      logic [DW-1:0] ev;
      s  = 2'($urandom_range(0, 3));
      ev = ($urandom_range(0, 2) == 0) ? DW'($urandom) : '0;
      step(s, 1'($urandom), DW'($urandom), ev);
      check_all("R2 R3 R5 R6 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule